// File: doc/BRIEF.md
# I2S Frame Serializer

This block turns 32-bit parallel audio words into a two-channel I2S serial data stream. An external master supplies the bit clock and the word-select signal. The block samples both on its own system clock and finds the edge at which data must change. Words come from a transmit FIFO through a valid/ready handshake. The block fetches one word for each channel slot and drives that slot's bits one at a time on the serial output.

Two lengths are configured separately: the slot length (bit clocks per channel) and the data word length. The part of the slot not filled by data is padding. A static configuration sets whether the padding comes before or after the data, and whether the padding bits are 0 or 1. It also sets whether the first bit is delayed by one bit clock after the word-select edge, which word-select level marks the first channel, and whether the word is taken from the top or the bottom of the 32-bit FIFO entry. A mute input silences the output while words continue to be consumed. A slot with no word ready produces an underflow pulse and is sent as all zeros.

Top module: `i2s_frame_serializer`

## Requirements
- R1: `cfg_slot_code` sets the slot length to 8, 16, 24 or 32 bits for codes 0, 1, 2 and 3. One slot carries that many bits, and word select is expected to toggle once per slot.
- R2: `cfg_word_code` sets the data word length to 8, 16, 18, 20, 22 or 24 bits for codes 0 to 5. Codes 6 and 7, and any word longer than the slot, make the block inactive: `in_ready` stays low and `sd_out` stays 0.
- R3: With `cfg_no_delay`=0, the first bit of a slot is driven at the launch edge that follows the word-select transition, and the slot's last bit is driven at the next transition. With `cfg_no_delay`=1, the first bit is driven at the transition edge itself.
- R4: Data bits are sent most significant bit first. With `cfg_pad_first`=0 the data bits come first and the padding last. With `cfg_pad_first`=1 the padding comes first and the data last.
- R5: Every padding bit equals `cfg_pad_high`.
- R6: After the block becomes active, it fetches its first word only at the start of a slot in which `ws` equals `cfg_ws_first_high`. From then on it fetches at the start of every slot. Slots before the first fetch are sent as zeros.
- R7: For word codes 2 to 5, `cfg_left_align`=1 takes the word from `in_data[31:32-n]` and `cfg_left_align`=0 takes it from `in_data[n-1:0]`. For codes 0 and 1 the word always comes from the low bits.
- R8: While `mute` is high, `sd_out` is 0. Words are still fetched at the start of every slot.
- R9: With `cfg_sck_rise_launch`=0, `sd_out` changes after falling edges of `sck`. With 1, it changes after rising edges. The update happens on the clock edge at which the block first sees the new `sck` level.
- R10: If `in_valid` is low when a fetch is due, `underflow` is high for exactly the next clock cycle and the whole slot is sent as zeros.
- R11: While `tx_en` is low, `sd_out` is 0 and `in_ready` stays low.
- R12: After reset, `sd_out`, `underflow` and `in_ready` are 0.
- R13: `in_ready` is high for the single clock cycle in which the block sees a slot's load edge. The word on `in_data` is taken if `in_valid` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Bit clock from the external master |
| ws | input | 1 | Word select from the external master |
| tx_en | input | 1 | Transmit enable |
| mute | input | 1 | Force serial output to 0, keep consuming words |
| cfg_slot_code | input | 2 | Slot length code |
| cfg_word_code | input | 3 | Data word length code |
| cfg_no_delay | input | 1 | 1: first bit at the word-select edge |
| cfg_pad_first | input | 1 | 1: padding precedes data in the slot |
| cfg_pad_high | input | 1 | Padding bit value |
| cfg_ws_first_high | input | 1 | Word-select level of the first channel |
| cfg_left_align | input | 1 | 1: take long words from the top of the entry |
| cfg_sck_rise_launch | input | 1 | 1: data changes on rising bit-clock edges |
| in_data | input | 32 | FIFO word |
| in_valid | input | 1 | FIFO word available |
| in_ready | output | 1 | Word taken this cycle when valid |
| sd_out | output | 1 | Serial data |
| underflow | output | 1 | One-cycle pulse for a slot with no word |

## Verification
Two cases are hard to reach from the ports. The first is the delayed-start mode, where the last bit of one slot is driven on the word-select edge that opens the next slot. The second is the channel lock after enabling: the block must skip a second-channel slot. To reach both, the bench sets up each run with two idle bit clocks while transmit is disabled, so the word-select history is known. It then starts some runs with an extra second-channel slot. For every edge, the bench model predicts which bit belongs to which slot and at which edge a fetch falls due. It checks serial data, ready and underflow across every legal pairing of slot length and word length.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;
  localparam int FIFO_W   = 32;
  localparam int SLOT_MAX = 32;
  localparam int SCODE_W  = 2;
  localparam int WCODE_W  = 3;

  function automatic int slot_bits(logic [SCODE_W-1:0] sc);
    return 8 * (int'(sc) + 1);
  endfunction

  function automatic int word_bits(logic [WCODE_W-1:0] wc);
    if (wc == 3'd0) return 8;
    if (wc == 3'd1) return 16;
    if (wc <= 3'd5) return 14 + 2 * int'(wc);
    return 0;
  endfunction

  function automatic logic cfg_ok(logic [WCODE_W-1:0] wc, logic [SCODE_W-1:0] sc);
    return (word_bits(wc) != 0) && (word_bits(wc) <= slot_bits(sc));
  endfunction

  // Slot image with the first bit to send at the top position.
  function automatic logic [SLOT_MAX-1:0] build_slot(
    logic [FIFO_W-1:0] w, logic [WCODE_W-1:0] wc, logic [SCODE_W-1:0] sc,
    logic pad_first, logic pad_high, logic left);
    int n;
    int l;
    logic [SLOT_MAX-1:0] d;
    logic [SLOT_MAX-1:0] ones;
    logic [SLOT_MAX-1:0] v;
    n = word_bits(wc);
    l = slot_bits(sc);
    ones = '1;
    if (wc >= 3'd2 && left) d = w >> (FIFO_W - n);
    else d = w & ~(ones << n);
    if (pad_first) v = (d << (SLOT_MAX - l)) | (pad_high ? ~(ones >> (l - n)) : '0);
    else v = (d << (SLOT_MAX - n)) | (pad_high ? (ones >> n) : '0);
    return v;
  endfunction
endpackage

// File: rtl/i2s_ser_edges.sv
module i2s_ser_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic ws,
  input  logic launch_rise,
  output logic shift_edge,
  output logic ws_toggle
);
  logic sck_q;
  logic ws_last;

  assign shift_edge = (sck != sck_q) && (sck == launch_rise);
  assign ws_toggle  = shift_edge && (ws != ws_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      ws_last <= 1'b0;
    end else begin
      sck_q <= sck;
      if (shift_edge) ws_last <= ws;
    end
  end

  // R9: a launch edge needs the bit clock to leave and return, never two in a row
  assert_edge_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_edge |=> !shift_edge) else $error("launch edges back to back");
endmodule

// File: rtl/i2s_ser_fetch.sv
module i2s_ser_fetch (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_edge,
  input  logic ws_toggle,
  input  logic ws,
  input  logic no_delay,
  input  logic ws_first_high,
  input  logic active,
  input  logic in_valid,
  output logic load,
  output logic fetch,
  output logic fetch_ok,
  output logic underflow
);
  logic bnd_d;
  logic started;
  logic first_ch;

  assign load     = shift_edge && (no_delay ? ws_toggle : bnd_d);
  assign first_ch = (ws == ws_first_high);
  assign fetch    = load && active && (started || first_ch);
  assign fetch_ok = fetch && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bnd_d     <= 1'b0;
      started   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (shift_edge) bnd_d <= ws_toggle;
      if (!active) started <= 1'b0;
      else if (fetch) started <= 1'b1;
      underflow <= fetch && !in_valid;
    end
  end

  assert_fetch_on_edge_R13: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> shift_edge) else $error("fetch away from a launch edge");
  assert_lock_first_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> $past(ws == ws_first_high)) else $error("locked on wrong channel");
  assert_underflow_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(!in_valid && shift_edge)) else $error("spurious underflow");
  assert_underflow_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow) else $error("underflow longer than one cycle");
endmodule

// File: rtl/i2s_ser_shift.sv
module i2s_ser_shift
  import i2s_ser_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_edge,
  input  logic                load,
  input  logic                fetch_ok,
  input  logic                active,
  input  logic                mute,
  input  logic [SLOT_MAX-1:0] slot_vec,
  output logic                sd
);
  logic [SLOT_MAX-1:0] shreg;
  logic [SLOT_MAX-1:0] vec_sel;

  assign vec_sel = fetch_ok ? slot_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      shreg <= '0;
      sd    <= 1'b0;
    end else if (shift_edge) begin
      if (load) begin
        sd    <= !mute && vec_sel[SLOT_MAX-1];
        shreg <= vec_sel << 1;
      end else begin
        sd    <= !mute && shreg[SLOT_MAX-1];
        shreg <= shreg << 1;
      end
    end
  end

  assert_mute_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_edge && mute) |=> !sd) else $error("muted output not zero");
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sd) else $error("inactive output not zero");
  assert_sd_moves_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> ($past(shift_edge) || $past(!active))) else $error("output moved off edge");
endmodule

// File: rtl/i2s_frame_serializer.sv
module i2s_frame_serializer
  import i2s_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ws,
  input  logic              tx_en,
  input  logic              mute,
  input  logic [1:0]        cfg_slot_code,
  input  logic [2:0]        cfg_word_code,
  input  logic              cfg_no_delay,
  input  logic              cfg_pad_first,
  input  logic              cfg_pad_high,
  input  logic              cfg_ws_first_high,
  input  logic              cfg_left_align,
  input  logic              cfg_sck_rise_launch,
  input  logic [FIFO_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              sd_out,
  output logic              underflow
);
  logic                active;
  logic                shift_edge;
  logic                ws_toggle;
  logic                load;
  logic                fetch;
  logic                fetch_ok;
  logic [SLOT_MAX-1:0] slot_vec;

  assign active   = tx_en && cfg_ok(cfg_word_code, cfg_slot_code);
  assign slot_vec = build_slot(in_data, cfg_word_code, cfg_slot_code,
                               cfg_pad_first, cfg_pad_high, cfg_left_align);
  assign in_ready = fetch;

  i2s_ser_edges u_edges (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck         (sck),
    .ws          (ws),
    .launch_rise (cfg_sck_rise_launch),
    .shift_edge  (shift_edge),
    .ws_toggle   (ws_toggle)
  );

  i2s_ser_fetch u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .shift_edge    (shift_edge),
    .ws_toggle     (ws_toggle),
    .ws            (ws),
    .no_delay      (cfg_no_delay),
    .ws_first_high (cfg_ws_first_high),
    .active        (active),
    .in_valid      (in_valid),
    .load          (load),
    .fetch         (fetch),
    .fetch_ok      (fetch_ok),
    .underflow     (underflow)
  );

  i2s_ser_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_edge (shift_edge),
    .load       (load),
    .fetch_ok   (fetch_ok),
    .active     (active),
    .mute       (mute),
    .slot_vec   (slot_vec),
    .sd         (sd_out)
  );

  assert_no_ready_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !in_ready) else $error("ready while disabled");
  assert_no_ready_bad_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_code > 3'd5) |-> !in_ready) else $error("ready with illegal word code");
endmodule

// File: tb/i2s_frame_serializer_bench.sv
module i2s_frame_serializer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic ws = 1'b0;
  logic tx_en = 1'b0;
  logic mute = 1'b0;
  logic [1:0] cfg_slot_code = '0;
  logic [2:0] cfg_word_code = '0;
  logic cfg_no_delay = 1'b0;
  logic cfg_pad_first = 1'b0;
  logic cfg_pad_high = 1'b0;
  logic cfg_ws_first_high = 1'b0;
  logic cfg_left_align = 1'b0;
  logic cfg_sck_rise_launch = 1'b0;
  logic [31:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic sd_out;
  logic underflow;

  int checks = 0;
  int failures = 0;
  int consumed = 0;
  int run_id = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2s_frame_serializer u_i2s_frame_serializer (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .tx_en(tx_en), .mute(mute),
    .cfg_slot_code(cfg_slot_code), .cfg_word_code(cfg_word_code),
    .cfg_no_delay(cfg_no_delay), .cfg_pad_first(cfg_pad_first),
    .cfg_pad_high(cfg_pad_high), .cfg_ws_first_high(cfg_ws_first_high),
    .cfg_left_align(cfg_left_align), .cfg_sck_rise_launch(cfg_sck_rise_launch),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .sd_out(sd_out), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (run %0d)", tag, act, exp, run_id);
    end
  endtask

  function automatic int b_slot(int sc);
    case (sc)
      0: return 8;
      1: return 16;
      2: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int b_word(int wc);
    case (wc)
      0: return 8;
      1: return 16;
      2: return 18;
      3: return 20;
      4: return 22;
      5: return 24;
      default: return 99;
    endcase
  endfunction

  function automatic logic [31:0] wval(int k);
    return 32'hC3A5_1E69 ^ (k * 32'h0101_0133) ^ (run_id << 5);
  endfunction

  // i-th bit sent in the slot that carries word w
  function automatic logic b_bit(logic [31:0] w, int i);
    int n;
    int l;
    int j;
    n = b_word(int'(cfg_word_code));
    l = b_slot(int'(cfg_slot_code));
    if (cfg_pad_first) begin
      if (i < l - n) return cfg_pad_high;
      j = i - (l - n);
    end else begin
      if (i >= n) return cfg_pad_high;
      j = i;
    end
    if (cfg_word_code >= 3'd2 && cfg_left_align) return w[31 - j];
    return w[n - 1 - j];
  endfunction

  task automatic do_edge(input logic lvl, output logic rdy, output logic uf, output logic sdv);
    @(negedge clk);
    sck = cfg_sck_rise_launch;
    ws = lvl;
    #1 rdy = in_ready;
    @(posedge clk);
    #1 uf = underflow;
    if (rdy && in_valid) begin
      consumed++;
      in_data = wval(consumed);
    end
    repeat (2) @(negedge clk);
    sck = ~cfg_sck_rise_launch;
    repeat (2) @(negedge clk);
    #1 sdv = sd_out;
  endtask

  task automatic run(input int nslots, input bit lead, input bit en, input bit vin,
                     input bit mute_v, input string tag);
    int n;
    int l;
    bit act;
    logic ws0;
    logic rdy;
    logic uf;
    logic sdv;
    logic exp_sd;
    bit exp_rdy;
    n = b_word(int'(cfg_word_code));
    l = b_slot(int'(cfg_slot_code));
    act = en && (n <= l);
    run_id++;
    tx_en = 1'b0;
    mute = mute_v;
    in_valid = vin;
    consumed = 0;
    in_data = wval(0);
    @(negedge clk);
    sck = ~cfg_sck_rise_launch;
    repeat (3) @(negedge clk);
    ws0 = lead ? ~cfg_ws_first_high : cfg_ws_first_high;
    for (int q = 0; q < 2; q++) begin
      do_edge(~ws0, rdy, uf, sdv);
      chk(sdv == 1'b0, {tag, " idle sd R11"}, int'(sdv), 0);
    end
    @(negedge clk);
    tx_en = en;
    for (int t = 0; t < nslots + int'(lead); t++) begin
      int k;
      logic lvl;
      k = t - int'(lead);
      lvl = (t % 2 == 0) ? ws0 : ~ws0;
      for (int p = 0; p < l; p++) begin
        do_edge(lvl, rdy, uf, sdv);
        exp_rdy = act && (k >= 0) && (cfg_no_delay ? (p == 0) : (p == 1));
        if (!act || mute_v || !vin) exp_sd = 1'b0;
        else if (cfg_no_delay) exp_sd = (k < 0) ? 1'b0 : b_bit(wval(k), p);
        else if (p == 0) exp_sd = (k < 1) ? 1'b0 : b_bit(wval(k - 1), l - 1);
        else exp_sd = (k < 0) ? 1'b0 : b_bit(wval(k), p - 1);
        chk(sdv === exp_sd, {tag, " sd"}, int'(sdv), int'(exp_sd));
        chk(rdy === exp_rdy, {tag, " in_ready R13"}, int'(rdy), int'(exp_rdy));
        chk(uf === (exp_rdy && !vin), {tag, " underflow R10"}, int'(uf), int'(exp_rdy && !vin));
      end
    end
    chk(consumed == ((act && vin) ? nslots : 0), {tag, " words taken"}, consumed,
        (act && vin) ? nslots : 0);
    tx_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: outputs quiet after reset
    chk(sd_out == 1'b0, "R12 sd_out", int'(sd_out), 0);
    chk(underflow == 1'b0, "R12 underflow", int'(underflow), 0);
    chk(in_ready == 1'b0, "R12 in_ready", int'(in_ready), 0);

    // R1 R3 R4 R5 R7 R9 R13: every legal slot/word pairing
    cnt = 0;
    for (int sc = 0; sc < 4; sc++) begin
      for (int wc = 0; wc < 6; wc++) begin
        if (b_word(wc) > b_slot(sc)) continue;
        for (int m = 0; m < 8; m++) begin
          cfg_slot_code = 2'(sc);
          cfg_word_code = 3'(wc);
          cfg_no_delay = m[0];
          cfg_pad_first = m[1];
          cfg_pad_high = m[2];
          cfg_ws_first_high = cnt[0];
          cfg_sck_rise_launch = cnt[1];
          cfg_left_align = cnt[2];
          cnt++;
          run(4, 0, 1, 1, 0, "R1/R3/R4/R5/R7/R9");
        end
      end
    end

    // R6: leading second-channel slot is skipped, both polarities and delays
    cfg_slot_code = 2'd1; cfg_word_code = 3'd1; cfg_pad_high = 1'b1; cfg_pad_first = 1'b0;
    for (int m = 0; m < 4; m++) begin
      cfg_ws_first_high = m[0];
      cfg_no_delay = m[1];
      run(3, 1, 1, 1, 0, "R6 lead slot");
    end

    // R2: illegal word code, and word longer than slot
    cfg_slot_code = 2'd3; cfg_word_code = 3'd6;
    run(2, 0, 1, 1, 0, "R2 code6");
    cfg_slot_code = 2'd1; cfg_word_code = 3'd5;
    run(2, 0, 1, 1, 0, "R2 oversize");

    // R8: mute keeps fetching
    cfg_slot_code = 2'd2; cfg_word_code = 3'd5; cfg_pad_high = 1'b1;
    run(4, 0, 1, 1, 1, "R8 mute");

    // R11: disabled
    run(2, 0, 0, 1, 0, "R11 disabled");

    // R10: no data ready, padding high would show if slot were not zeroed
    cfg_pad_first = 1'b1;
    run(4, 0, 1, 0, 0, "R10 empty fifo");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule